// File: doc/BRIEF.md
# Lane-Mask Compare, Register-Tested Branch and Halt Unit

This unit runs a small set of operations on a file of 128-bit general registers and keeps no condition flags. A compare takes two source registers, holds them against each other lane by lane and writes the outcome into a destination register. Each lane of the result is either all ones, when the relation holds, or all zeros. The compare can run on four 32-bit lanes or on eight 16-bit lanes, and it can test equality, signed greater-than or unsigned greater-than.

Control flow reads those registers directly. A branch looks only at the scalar slot of one register, which is bits [127:96], and picks either a PC-relative target or the next sequential address. A halt compares the scalar slots of two registers as signed values. When the comparison holds, the halt stops the unit for good: it is imprecise and cannot be resumed, so only a reset clears it.

A load operation fills a register with a full 128-bit value. A combinational read port shows any register, which lets the surrounding logic see the results.

Top module: `simd_cmp_unit`

## Requirements
- R1: After reset `pcOut` equals RESET_PC (default 0), `halted` is low and every register reads zero.
- R2: An accepted operation with `opCode` 1 writes `ldData` into register `rT`. `rdData` always shows register `rdIdx` combinationally.
- R3: Opcodes 2, 3 and 4 compare `rA` with `rB` on four 32-bit lanes, testing equality, signed `rA > rB` and unsigned `rA > rB` respectively. Each lane of `rT` becomes all ones when its test holds and all zeros when it does not.
- R4: Opcodes 5, 6 and 7 perform the same three tests on eight 16-bit lanes and write lane masks of the same form into `rT`.
- R5: Source operands are read before the write takes effect, so `rT` may name the same register as `rA` or `rB`.
- R6: Opcode 8 (branch if non-zero) sets the PC to PC + 4 × sign-extended `brOffset` when bits [127:96] of `rA` are non-zero, and to PC + 4 otherwise. No other lane affects the decision.
- R7: Opcode 9 (branch if zero) takes the same target when bits [127:96] of `rA` are zero, and moves to PC + 4 otherwise.
- R8: An accepted opcode 0, a load, a compare, or any undefined opcode (11 to 15) advances the PC by 4. The PC holds while `opValid` is low. Branches and halts write no register.
- R9: Opcode 10 (halt if greater) raises `halted` when bits [127:96] of `rA` are signed-greater than those of `rB`. In that case the PC does not advance. When the test fails, the PC advances by 4.
- R10: Once `halted` is set it stays set until reset. While it is set, no register is written and the PC never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation selector |
| rA | input | 3 | First source register index |
| rB | input | 3 | Second source register index |
| rT | input | 3 | Destination register index |
| ldData | input | 128 | Value written by the load operation |
| brOffset | input | 16 | Signed branch offset in words |
| rdIdx | input | 3 | Read port register index |
| rdData | output | 128 | Contents of register rdIdx |
| pcOut | output | 32 | Program counter |
| halted | output | 1 | Sticky halt indication |

## Verification
A fault in a compare lane is stored in a general register. It shows up on `rdData` in the cycle after the compare, as a lane that does not match the mask the bench expects, or as a lane that is neither all ones nor all zeros. A wrong branch or halt decision moves `pcOut` to the wrong value one edge after the operation. A halt flag that clears or lets writes through shows up on the first operation issued after the halt: the PC moves, or a register that should have stayed the same has changed.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_CEQW  = 4'd2;
  localparam logic [3:0] OP_CGTW  = 4'd3;
  localparam logic [3:0] OP_CLGTW = 4'd4;
  localparam logic [3:0] OP_CEQH  = 4'd5;
  localparam logic [3:0] OP_CGTH  = 4'd6;
  localparam logic [3:0] OP_CLGTH = 4'd7;
  localparam logic [3:0] OP_BRNZ  = 4'd8;
  localparam logic [3:0] OP_BRZ   = 4'd9;
  localparam logic [3:0] OP_HGT   = 4'd10;

  typedef enum logic [1:0] {CMP_EQ, CMP_GT, CMP_LGT} cmpKind_e;

  typedef struct packed {
    logic     wrEn;
    logic     wrLoad;
    logic     laneHalf;
    cmpKind_e kind;
    logic     pcStep;
    logic     pcBranch;
    logic     haltSet;
  } ctrlStrobes_t;
endpackage

// File: rtl/simd_cmp_ctrl.sv
module simd_cmp_ctrl
  import simd_cmp_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [SLOT_W-1:0] slotA,
  input  logic [SLOT_W-1:0] slotB,
  output ctrlStrobes_t      strb,
  output logic              halted
);
  logic live;
  assign live = opValid && !halted;

  always_comb begin
    strb = '0;
    strb.kind = CMP_EQ;
    if (live) begin
      case (opCode)
        OP_LOAD:  begin strb.wrEn = 1'b1; strb.wrLoad = 1'b1; strb.pcStep = 1'b1; end
        OP_CEQW:  begin strb.wrEn = 1'b1; strb.kind = CMP_EQ;  strb.pcStep = 1'b1; end
        OP_CGTW:  begin strb.wrEn = 1'b1; strb.kind = CMP_GT;  strb.pcStep = 1'b1; end
        OP_CLGTW: begin strb.wrEn = 1'b1; strb.kind = CMP_LGT; strb.pcStep = 1'b1; end
        OP_CEQH:  begin strb.wrEn = 1'b1; strb.laneHalf = 1'b1; strb.kind = CMP_EQ;  strb.pcStep = 1'b1; end
        OP_CGTH:  begin strb.wrEn = 1'b1; strb.laneHalf = 1'b1; strb.kind = CMP_GT;  strb.pcStep = 1'b1; end
        OP_CLGTH: begin strb.wrEn = 1'b1; strb.laneHalf = 1'b1; strb.kind = CMP_LGT; strb.pcStep = 1'b1; end
        OP_BRNZ: begin
          if (slotA != '0) strb.pcBranch = 1'b1;
          else             strb.pcStep   = 1'b1;
        end
        OP_BRZ: begin
          if (slotA == '0) strb.pcBranch = 1'b1;
          else             strb.pcStep   = 1'b1;
        end
        OP_HGT: begin
          if ($signed(slotA) > $signed(slotB)) strb.haltSet = 1'b1;
          else                                 strb.pcStep  = 1'b1;
        end
        default: strb.pcStep = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             halted <= 1'b0;
    else if (strb.haltSet) halted <= 1'b1;
  end
endmodule

// File: rtl/simd_cmp_dp.sv
module simd_cmp_dp
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int WORD_W   = 32,
  parameter int HALF_W   = 16,
  parameter int NREGS    = 8,
  parameter int PC_W     = 32,
  parameter int OFF_W    = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int IDX_W   = $clog2(NREGS),
  localparam int WLANES  = DATA_W / WORD_W,
  localparam int HLANES  = DATA_W / HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [IDX_W-1:0]  rA,
  input  logic [IDX_W-1:0]  rB,
  input  logic [IDX_W-1:0]  rT,
  input  logic [DATA_W-1:0] ldData,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [WORD_W-1:0] slotA,
  output logic [WORD_W-1:0] slotB,
  output logic [DATA_W-1:0] wrData,
  output logic [PC_W-1:0]   pcOut
);
  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] opA, opB, maskW, maskH;

  assign opA    = regs[rA];
  assign opB    = regs[rB];
  assign rdData = regs[rdIdx];
  assign slotA  = opA[DATA_W-1 -: WORD_W];
  assign slotB  = opB[DATA_W-1 -: WORD_W];

  for (genvar i = 0; i < WLANES; i++) begin : g_word
    logic [WORD_W-1:0] la, lb;
    logic hit;
    assign la = opA[i*WORD_W +: WORD_W];
    assign lb = opB[i*WORD_W +: WORD_W];
    always_comb begin
      case (strb.kind)
        CMP_EQ:  hit = (la == lb);
        CMP_GT:  hit = ($signed(la) > $signed(lb));
        default: hit = (la > lb);
      endcase
    end
    assign maskW[i*WORD_W +: WORD_W] = {WORD_W{hit}};
  end

  for (genvar i = 0; i < HLANES; i++) begin : g_half
    logic [HALF_W-1:0] la, lb;
    logic hit;
    assign la = opA[i*HALF_W +: HALF_W];
    assign lb = opB[i*HALF_W +: HALF_W];
    always_comb begin
      case (strb.kind)
        CMP_EQ:  hit = (la == lb);
        CMP_GT:  hit = ($signed(la) > $signed(lb));
        default: hit = (la > lb);
      endcase
    end
    assign maskH[i*HALF_W +: HALF_W] = {HALF_W{hit}};
  end

  assign wrData = strb.wrLoad ? ldData : (strb.laneHalf ? maskH : maskW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
    end else if (strb.wrEn) begin
      regs[rT] <= wrData;
    end
  end

  logic [PC_W-1:0] brDelta;
  assign brDelta = {{(PC_W-OFF_W-2){brOffset[OFF_W-1]}}, brOffset, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN)              pcOut <= RESET_PC;
    else if (strb.pcBranch) pcOut <= pcOut + brDelta;
    else if (strb.pcStep)   pcOut <= pcOut + PC_W'(4);
  end
endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int NREGS  = 8,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [IDX_W-1:0]  rA,
  input  logic [IDX_W-1:0]  rB,
  input  logic [IDX_W-1:0]  rT,
  input  logic [DATA_W-1:0] ldData,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [PC_W-1:0]   pcOut,
  output logic              halted
);
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  ctrlStrobes_t      strb;
  logic [WORD_W-1:0] slotA, slotB;
  logic [DATA_W-1:0] wrData;
  logic              topWrEn, topCmpWord;

  assign topWrEn    = strb.wrEn;
  assign topCmpWord = strb.wrEn && !strb.wrLoad && !strb.laneHalf;

  simd_cmp_ctrl #(.SLOT_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .slotA(slotA), .slotB(slotB), .strb(strb), .halted(halted)
  );

  simd_cmp_dp #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .HALF_W(HALF_W), .NREGS(NREGS),
    .PC_W(PC_W), .OFF_W(OFF_W), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rA(rA), .rB(rB), .rT(rT),
    .ldData(ldData), .brOffset(brOffset), .rdIdx(rdIdx), .rdData(rdData),
    .slotA(slotA), .slotB(slotB), .wrData(wrData), .pcOut(pcOut)
  );
endmodule

// File: rtl/simd_cmp_chk.sv
module simd_cmp_chk
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int PC_W   = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic              halted,
  input logic [PC_W-1:0]   pcOut,
  input logic [WORD_W-1:0] slotA,
  input logic [WORD_W-1:0] slotB,
  input logic              wrEn,
  input logic              cmpWord,
  input logic [DATA_W-1:0] wrData
);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R10
  halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(pcOut));

  // R10
  halt_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !wrEn);

  // R8
  nop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !halted && opCode == OP_NOP) |=> (pcOut == $past(pcOut) + PC_W'(4)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !halted) |=> $stable(pcOut));

  // R9
  halt_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !halted && opCode == OP_HGT && $signed(slotA) > $signed(slotB)) |=> halted);

  for (genvar i = 0; i < DATA_W / WORD_W; i++) begin : g_lane
    // R3
    word_lane_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmpWord |-> (wrData[i*WORD_W +: WORD_W] == '0 || wrData[i*WORD_W +: WORD_W] == '1));
  end
endmodule

bind simd_cmp_unit simd_cmp_chk #(.DATA_W(DATA_W), .PC_W(PC_W), .WORD_W(32)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .halted(halted),
  .pcOut(pcOut), .slotA(slotA), .slotB(slotB), .wrEn(topWrEn),
  .cmpWord(topCmpWord), .wrData(wrData)
);

// File: tb/simd_cmp_unit_test.sv
module simd_cmp_unit_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [3:0]   opCode = '0;
  logic [2:0]   rA = '0, rB = '0, rT = '0, rdIdx = '0;
  logic [127:0] ldData = '0;
  logic [15:0]  brOffset = '0;
  logic [127:0] rdData;
  logic [31:0]  pcOut;
  logic         halted;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expPc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_cmp_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .rA(rA), .rB(rB), .rT(rT), .ldData(ldData), .brOffset(brOffset),
    .rdIdx(rdIdx), .rdData(rdData), .pcOut(pcOut), .halted(halted)
  );

  localparam logic [127:0] VA = {32'h0000_0005, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
  localparam logic [127:0] VB = {32'h0000_0005, 32'h0000_0001, 32'h7FFF_FFFF, 32'h1234_5679};
  localparam logic [127:0] VZ = {32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0001, 32'h0000_0002};
  localparam logic [127:0] VN = {32'hFFFF_FFFF, 96'h0};

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expCmp(input logic [127:0] a, input logic [127:0] b,
                                         input int w, input int kind);
    logic [127:0] r = '0;
    for (int l = 0; l < 128 / w; l++) begin
      logic hit;
      if (w == 32) begin
        logic [31:0] x = a[l*32 +: 32];
        logic [31:0] y = b[l*32 +: 32];
        hit = (kind == 0) ? (x == y) : (kind == 1) ? ($signed(x) > $signed(y)) : (x > y);
        r[l*32 +: 32] = {32{hit}};
      end else begin
        logic [15:0] x = a[l*16 +: 16];
        logic [15:0] y = b[l*16 +: 16];
        hit = (kind == 0) ? (x == y) : (kind == 1) ? ($signed(x) > $signed(y)) : (x > y);
        r[l*16 +: 16] = {16{hit}};
      end
    end
    return r;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [2:0] t, input logic [2:0] a,
                       input logic [2:0] b, input logic [127:0] d, input logic [15:0] off);
    @(negedge clk);
    opValid = 1'b1; opCode = op; rT = t; rA = a; rB = b; ldData = d; brOffset = off;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [127:0] v);
    rdIdx = idx;
    #1;
    v = rdData;
  endtask

  task automatic testReset();
    logic [127:0] v;
    check({96'h0, pcOut}, 128'h0, "R1 pc after reset");
    check({127'h0, halted}, 128'h0, "R1 halted after reset");
    readReg(3'd5, v);
    check(v, 128'h0, "R1 register zero after reset");
  endtask

  task automatic testLoad();
    logic [127:0] v;
    issue(4'd1, 3'd1, 3'd0, 3'd0, VA, '0); expPc += 4;
    issue(4'd1, 3'd2, 3'd0, 3'd0, VB, '0); expPc += 4;
    issue(4'd1, 3'd3, 3'd0, 3'd0, VZ, '0); expPc += 4;
    issue(4'd1, 3'd4, 3'd0, 3'd0, VN, '0); expPc += 4;
    readReg(3'd1, v); check(v, VA, "R2 load r1");
    readReg(3'd3, v); check(v, VZ, "R2 load r3");
    check({96'h0, pcOut}, {96'h0, expPc}, "R8 pc after loads");
  endtask

  task automatic testWordCmp();
    logic [127:0] v;
    issue(4'd2, 3'd5, 3'd1, 3'd2, '0, '0); expPc += 4;
    readReg(3'd5, v); check(v, expCmp(VA, VB, 32, 0), "R3 word equal");
    issue(4'd3, 3'd5, 3'd2, 3'd1, '0, '0); expPc += 4;
    readReg(3'd5, v); check(v, expCmp(VB, VA, 32, 1), "R3 word signed gt");
    issue(4'd4, 3'd5, 3'd1, 3'd2, '0, '0); expPc += 4;
    readReg(3'd5, v); check(v, expCmp(VA, VB, 32, 2), "R3 word unsigned gt");
    issue(4'd3, 3'd5, 3'd1, 3'd2, '0, '0); expPc += 4;
    readReg(3'd5, v); check(v, expCmp(VA, VB, 32, 1), "R3 word signed gt reversed");
  endtask

  task automatic testHalfCmp();
    logic [127:0] v;
    issue(4'd5, 3'd6, 3'd1, 3'd2, '0, '0); expPc += 4;
    readReg(3'd6, v); check(v, expCmp(VA, VB, 16, 0), "R4 half equal");
    issue(4'd6, 3'd6, 3'd1, 3'd2, '0, '0); expPc += 4;
    readReg(3'd6, v); check(v, expCmp(VA, VB, 16, 1), "R4 half signed gt");
    issue(4'd7, 3'd6, 3'd1, 3'd2, '0, '0); expPc += 4;
    readReg(3'd6, v); check(v, expCmp(VA, VB, 16, 2), "R4 half unsigned gt");
  endtask

  task automatic testAlias();
    logic [127:0] v;
    issue(4'd1, 3'd7, 3'd0, 3'd0, VB, '0); expPc += 4;
    issue(4'd4, 3'd7, 3'd1, 3'd7, '0, '0); expPc += 4;
    readReg(3'd7, v); check(v, expCmp(VA, VB, 32, 2), "R5 destination aliases source");
  endtask

  task automatic testBranch();
    issue(4'd8, 3'd0, 3'd3, 3'd0, '0, 16'd5); expPc += 4;
    check({96'h0, pcOut}, {96'h0, expPc}, "R6 bnz not taken, slot zero");
    issue(4'd8, 3'd0, 3'd1, 3'd0, '0, 16'd5); expPc += 20;
    check({96'h0, pcOut}, {96'h0, expPc}, "R6 bnz taken forward");
    issue(4'd9, 3'd0, 3'd3, 3'd0, '0, 16'hFFFD); expPc -= 12;
    check({96'h0, pcOut}, {96'h0, expPc}, "R7 bz taken backward");
    issue(4'd9, 3'd0, 3'd1, 3'd0, '0, 16'hFFFD); expPc += 4;
    check({96'h0, pcOut}, {96'h0, expPc}, "R7 bz not taken");
    issue(4'd0, 3'd0, 3'd0, 3'd0, '0, '0); expPc += 4;
    issue(4'd13, 3'd0, 3'd0, 3'd0, '0, '0); expPc += 4;
    repeat (3) @(negedge clk);
    check({96'h0, pcOut}, {96'h0, expPc}, "R8 nop, undefined op and idle");
  endtask

  task automatic testHalt();
    logic [127:0] v;
    issue(4'd10, 3'd0, 3'd1, 3'd2, '0, '0); expPc += 4;
    check({127'h0, halted}, 128'h0, "R9 equal slots do not halt");
    check({96'h0, pcOut}, {96'h0, expPc}, "R9 pc steps on false halt");
    issue(4'd10, 3'd0, 3'd4, 3'd1, '0, '0); expPc += 4;
    check({127'h0, halted}, 128'h0, "R9 signed slot -1 not greater than 5");
    issue(4'd10, 3'd0, 3'd1, 3'd4, '0, '0);
    check({127'h0, halted}, 128'h1, "R9 halt when greater");
    check({96'h0, pcOut}, {96'h0, expPc}, "R9 pc not advanced by halt");
    issue(4'd1, 3'd1, 3'd0, 3'd0, VZ, '0);
    readReg(3'd1, v); check(v, VA, "R10 load ignored while halted");
    issue(4'd2, 3'd2, 3'd1, 3'd1, '0, '0);
    readReg(3'd2, v); check(v, VB, "R10 compare ignored while halted");
    issue(4'd8, 3'd0, 3'd1, 3'd0, '0, 16'd9);
    repeat (4) @(negedge clk);
    check({96'h0, pcOut}, {96'h0, expPc}, "R10 pc frozen while halted");
    check({127'h0, halted}, 128'h1, "R10 halted sticky");
  endtask

  task automatic testReReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expPc = '0;
    testReset();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoad();
    testWordCmp();
    testHalfCmp();
    testAlias();
    testBranch();
    testHalt();
    testReReset();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule